// File: doc/BRIEF.md
# Interrupt Collector with Keyed Soft Reset

This block sits beside a serial-peripheral controller on the same 32-bit register bus. Single-cycle event pulses from the controller are held in a status register. Software clears them by writing ones. A per-source enable mask and a global enable gate the pending bits onto one interrupt line.

A separate reset register lets software restart the peripheral. The restart happens only when software writes the exact key value. The block then raises a reset pulse for a fixed number of cycles and empties its own status and enable registers. Any other value written there leaves the peripheral running and raises an internal key-error source instead.

The register bus is a plain write strobe with an address and write data. Read data is combinational from the address. Register offsets are fixed, because software decodes them.

Top module: `spi_irq_ctl`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and `periph_rst_o` is low.
- R2: The global-enable register at offset 0x1C stores only bit 31. Reads return that bit in position 31 and zero in every other bit.
- R3: The status register at offset 0x20 latches `evt_i[k]` into bit k whatever the enable mask holds. The bit positions are: 0 mode fault, 1 slave-mode fault, 2 TX empty, 3 TX underrun, 4 RX full, 5 RX overrun, 6 TX half empty. Bit 7 is the key error. Bits 31..8 read zero.
- R4: A write to offset 0x20 clears each status bit whose write-data bit is one and leaves the others. An event pulse arriving in the same cycle as its clear leaves the bit set.
- R5: The enable register at offset 0x28 holds bits 7..0 as written, and bits 31..8 read zero. Writing zero masks every source.
- R6: `irq_o` is high exactly when the global enable is set and some status bit is set together with its enable bit. It follows the registers in the same cycle.
- R7: Writing 0x0000000A to offset 0x40 drives `periph_rst_o` high for RST_CYCLES cycles (4 by default), starting the cycle after the write. The write and every reset cycle clear status and enable, and events and enable writes in those cycles are dropped.
- R8: The soft reset leaves the global-enable register unchanged.
- R9: Writing any value other than 0x0000000A to offset 0x40 does not assert `periph_rst_o` and sets status bit 7.
- R10: Writes to offset 0x40 while `periph_rst_o` is high have no effect. They neither restart the pulse nor set status bit 7.
- R11: Reads of offset 0x40 and of unmapped offsets return zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| evt_i | input | NEVT | One-cycle event pulses from the controller |
| irq_o | output | 1 | Combined interrupt line |
| periph_rst_o | output | 1 | Peripheral reset pulse |

## Verification
The embedded assertions check, on every cycle, three properties:
- an event outside a reset window is always captured in status;
- status and enable stay zero while the reset pulse is high;
- a wrong key sets the error bit without starting a reset.

They also check that the global enable is not disturbed by the pulse. The bench's scenarios are needed for the rest:
- the exact pulse length;
- the event-wins-over-clear collision;
- the masking interplay behind the interrupt line;
- the rejection of key writes during an active pulse.

Each of these depends on a chosen ordering of writes and events.

// File: rtl/spi_irq_ctl.sv
module spi_irq_ctl #(
  parameter int          NEVT       = 7,
  parameter int          ADDR_W     = 8,
  parameter int          RST_CYCLES = 4,
  parameter logic [31:0] KEY        = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NEVT-1:0]   evt_i,
  output logic              irq_o,
  output logic              periph_rst_o
);
  localparam int NSRC = NEVT + 1;
  localparam int CW   = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] OFF_GIE = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] OFF_ST  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFF_EN  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] OFF_RST = ADDR_W'('h40);

  logic            gie_q;
  logic [NSRC-1:0] st_q, en_q;
  logic [CW-1:0]   cnt_q;
  logic            busy, key_wr, key_ok, key_bad;

  assign busy    = (cnt_q != '0);
  assign key_wr  = bus_wr_i && (bus_addr_i == OFF_RST) && !busy;
  assign key_ok  = key_wr && (bus_wdata_i == KEY);
  assign key_bad = key_wr && (bus_wdata_i != KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else if (bus_wr_i && bus_addr_i == OFF_GIE) gie_q <= bus_wdata_i[31];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else if (key_ok || busy) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      if (bus_wr_i && bus_addr_i == OFF_ST)
        st_q <= (st_q & ~bus_wdata_i[NSRC-1:0]) | {key_bad, evt_i};
      else
        st_q <= st_q | {key_bad, evt_i};
      if (bus_wr_i && bus_addr_i == OFF_EN) en_q <= bus_wdata_i[NSRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (key_ok) cnt_q <= CW'(RST_CYCLES);
    else if (busy)   cnt_q <= cnt_q - 1'b1;
  end

  assign periph_rst_o = busy;
  assign irq_o        = gie_q && |(st_q & en_q);

  always_comb begin
    case (bus_addr_i)
      OFF_GIE: bus_rdata_o = {gie_q, 31'b0};
      OFF_ST:  bus_rdata_o = {{(32-NSRC){1'b0}}, st_q};
      OFF_EN:  bus_rdata_o = {{(32-NSRC){1'b0}}, en_q};
      default: bus_rdata_o = '0;
    endcase
  end

  AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i && !busy && !key_ok) |=> ((st_q[NEVT-1:0] & $past(evt_i)) == $past(evt_i))); // R3
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_o |-> (st_q == '0 && en_q == '0)); // R7
  AST_GIE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_rst_o && !(bus_wr_i && bus_addr_i == OFF_GIE)) |=> $stable(gie_q)); // R8
  AST_BAD_KEY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == OFF_RST && bus_wdata_i != KEY && !periph_rst_o)
      |=> (st_q[NEVT] && !periph_rst_o)); // R9
endmodule

// File: tb/spi_irq_ctl_bench.sv
module spi_irq_ctl_bench;
  localparam int NEVT = 7;
  localparam int RSTC = 4;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NEVT-1:0] evt = 0;
  logic irq, prst;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  bit m_gie;
  bit [7:0] m_st, m_en;
  int m_cnt;

  always #4 clk = ~clk;

  spi_irq_ctl u_spi_irq_ctl (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .evt_i(evt),
    .irq_o(irq), .periph_rst_o(prst));

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h1C:   return {m_gie, 31'b0};
      8'h20:   return {24'b0, m_st};
      8'h28:   return {24'b0, m_en};
      default: return 32'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gie = 0; m_st = 0; m_en = 0; m_cnt = 0;
    end else begin
      bit busy, kok, kbad;
      busy = (m_cnt != 0);
      kok  = bus_wr && bus_addr == 8'h40 && !busy && bus_wdata == 32'hA;
      kbad = bus_wr && bus_addr == 8'h40 && !busy && bus_wdata != 32'hA;
      if (bus_wr && bus_addr == 8'h1C) m_gie = bus_wdata[31];
      if (kok || busy) begin
        m_st = 0; m_en = 0;
      end else begin
        if (bus_wr && bus_addr == 8'h20) m_st = m_st & ~bus_wdata[7:0];
        if (bus_wr && bus_addr == 8'h28) m_en = bus_wdata[7:0];
        m_st = m_st | {kbad, evt};
      end
      if (kok) m_cnt = RSTC;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      #1;
      check("R6 irq", {31'b0, irq}, {31'b0, m_gie && |(m_st & m_en)});
      check("R7 rst", {31'b0, prst}, {31'b0, m_cnt != 0});
      check("R11 rdata", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wait (cyc > 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #2;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [NEVT-1:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rd("R1 gie", 8'h1C, 0);
    rd("R1 st", 8'h20, 0);
    rd("R1 en", 8'h28, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rst", {31'b0, prst}, 0);
    rst_n = 1;
    rd("R1 st after release", 8'h20, 0);

    wr(8'h1C, 32'hFFFF_FFFF);
    rd("R2 gie bit31 only", 8'h1C, 32'h8000_0000);
    wr(8'h1C, 32'h7FFF_FFFF);
    rd("R2 gie cleared", 8'h1C, 0);
    wr(8'h1C, 32'h8000_0000);

    pulse(7'h05);
    rd("R3 latch while masked", 8'h20, 32'h05);
    check("R6 masked no irq", {31'b0, irq}, 0);

    wr(8'h28, 32'hFFFF_FF04);
    rd("R5 enable low byte", 8'h28, 32'h04);
    check("R6 irq up", {31'b0, irq}, 1);
    wr(8'h1C, 0);
    check("R6 gie gates", {31'b0, irq}, 0);
    wr(8'h1C, 32'h8000_0000);

    wr(8'h20, 32'h01);
    rd("R4 w1c partial", 8'h20, 32'h04);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h20; bus_wdata = 32'h04; evt = 7'h04;
    @(negedge clk);
    bus_wr = 0; evt = 0;
    rd("R4 event wins clear", 8'h20, 32'h04);
    wr(8'h20, 32'hFF);
    rd("R4 cleared", 8'h20, 0);
    wr(8'h28, 0);
    rd("R5 zero masks", 8'h28, 0);

    wr(8'h40, 32'h0000_010A);
    rd("R9 bad key flag", 8'h20, 32'h80);
    check("R9 no reset", {31'b0, prst}, 0);
    wr(8'h28, 32'h80);
    check("R9 error irq", {31'b0, irq}, 1);

    pulse(7'h40);
    wr(8'h40, 32'h0000_000A);
    check("R7 pulse high", {31'b0, prst}, 1);
    rd("R7 status zero", 8'h20, 0);
    rd("R7 enable zero", 8'h28, 0);
    wr(8'h40, 32'h5);
    rd("R10 ignored in reset", 8'h20, 0);
    repeat (4) @(negedge clk);
    check("R7 pulse ended", {31'b0, prst}, 0);
    rd("R8 gie kept", 8'h1C, 32'h8000_0000);
    wr(8'h40, 32'hA);
    pulse(7'h7F);
    rd("R7 events dropped", 8'h20, 0);
    repeat (4) @(negedge clk);

    wr(8'h30, 32'hFFFF_FFFF);
    rd("R11 unmapped read", 8'h30, 0);
    rd("R11 reset reg read", 8'h40, 0);
    rd("R11 en untouched", 8'h28, 0);

    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 9);
      @(negedge clk);
      evt = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h0;
      bus_wr = (r < 6);
      case (r % 5)
        0: bus_addr = 8'h1C;
        1: bus_addr = 8'h20;
        2: bus_addr = 8'h28;
        3: bus_addr = 8'h40;
        default: bus_addr = 8'h30;
      endcase
      bus_wdata = ($urandom_range(0, 2) == 0) ? 32'hA : $urandom;
    end
    @(negedge clk);
    bus_wr = 0; evt = 0;
    repeat (8) @(negedge clk);
    finish_run();
  end
endmodule